// File: doc/BRIEF.md
# Register Valid-Bit Scoreboard Interlock

This block is the hazard interlock for a five-stage in-order pipeline (fetch, operand fetch, execute, memory, operand store). It keeps one ready flag per architectural register. A set flag means the register file already holds the register's final value. A clear flag means some instruction that has already issued will still write the register. The datapath, the ALU and any forwarding network are outside this block.

The operand-fetch stage presents one instruction each cycle. The instruction carries up to two source register IDs and one destination ID, and each ID has its own use flag. The block answers in the same cycle:

- **Stall** when any used source is pending, or when the used destination is already pending. Holding the instruction on a pending destination keeps a second writer from issuing while the first write is still outstanding. Without that, later readers could pick up the older result.
- **Go** otherwise. The block then clears the destination's flag at the next clock edge.

The operand-store stage presents a write-back ID, which sets that register's flag again. A write-back counts for a reader that is checking the same register in the same cycle.

Top module: `regval_scoreboard`

## Requirements
- R1: While reset is asserted and after it is released, every bit of `ready_o` is 1.
- R2: When `iss_req` is high, `iss_dst_use` is high and no hazard exists, `iss_go` is 1 and `iss_stall` is 0 in that cycle. After the next clock edge, bit `iss_dst_id` of `ready_o` is 0.
- R3: When `iss_req` is high and any source with its use bit set names a register whose ready bit is 0, `iss_stall` is 1 and `iss_go` is 0, and `ready_o` does not change because of the request. Source k occupies bits [k*ID_W +: ID_W] of `iss_src_id`.
- R4: When `iss_req` is high and the used destination names a register whose ready bit is already 0, the instruction stalls and does not clear any bit. This prevents an output hazard: in the sequence write R3, write R3, read R3, the reader proceeds only after the second writer's write-back.
- R5: A cycle with `wb_en` high sets bit `wb_id` of `ready_o` to 1 after the next clock edge, unless R7 applies.
- R6: A write-back in the same cycle as an operand check of the same register makes that register count as ready, so the request does not stall on it.
- R7: When an issuing instruction's destination equals the write-back ID of the same cycle, the register's ready bit is 0 after the edge.
- R8: An instruction whose destination is also one of its sources is checked on its sources before its destination is cleared. It proceeds when the register is ready and stalls when the register is pending.
- R9: A source or destination ID whose use bit is 0 has no effect on the stall decision or on `ready_o`.
- R10: Several later readers of one pending register all stall on that single bit, and each proceeds once the write-back has set it.
- R11: With `iss_req` low, `iss_go` and `iss_stall` are both 0 and no ready bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| iss_req | input | 1 | Operand-fetch stage holds an instruction |
| iss_src_use | input | NUM_SRC | Per-source use flags |
| iss_src_id | input | NUM_SRC*ID_W | Source register IDs; source k at bits [k*ID_W +: ID_W] |
| iss_dst_use | input | 1 | Instruction writes a register |
| iss_dst_id | input | ID_W | Destination register ID |
| wb_en | input | 1 | Operand-store stage writes a register this cycle |
| wb_id | input | ID_W | Register written back |
| iss_go | output | 1 | Instruction may leave operand fetch |
| iss_stall | output | 1 | Instruction must be held in operand fetch |
| ready_o | output | NUM_REGS | Per-register ready flags (1 = no write pending) |

## Verification
The bench builds the block with eight registers and two sources. At that size, every pairing of a pending register with every source slot and every destination ID can be swept. This covers matching and non-matching IDs for both stall causes (R3, R4). A reference vector of ready bits, computed in the bench, predicts `iss_go`, `iss_stall` and `ready_o` every cycle. Directed sequences then cover the same-cycle write-back cases, the self-dependent instruction, the multiple-reader wait and the double-writer ordering.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Stall causes found in one operand-fetch check.
  typedef struct packed {
    logic src_pending;
    logic dst_pending;
  } sb_haz_t;

  function automatic logic sb_any_haz(input sb_haz_t h);
    return h.src_pending | h.dst_pending;
  endfunction

endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/sb_id_decode.sv
module sb_id_decode #(
  parameter int NUM_REGS = 32,
  parameter int ID_W     = 5
) (
  input  logic                en,
  input  logic [ID_W-1:0]     id,
  output logic [NUM_REGS-1:0] onehot
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign onehot[g] = en && (id == ID_W'(g));
  end

endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  parameter int ID_W     = 5
) (
  input  logic [NUM_REGS-1:0]     ready_eff,
  input  logic [NUM_SRC-1:0]      src_use,
  input  logic [NUM_SRC*ID_W-1:0] src_id,
  input  logic                    dst_use,
  input  logic [ID_W-1:0]         dst_id,
  output sb_haz_t                 haz
);

  logic [NUM_SRC-1:0] src_busy;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [ID_W-1:0] sid;
    assign sid         = src_id[k*ID_W +: ID_W];
    assign src_busy[k] = src_use[k] && !ready_eff[sid];
  end

  always_comb begin
    haz.src_pending = |src_busy;
    haz.dst_pending = dst_use && !ready_eff[dst_id];
  end

endmodule

// File: rtl/sb_valid_bits.sv
module sb_valid_bits #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_vec,
  input  logic [NUM_REGS-1:0] clr_vec,
  output logic [NUM_REGS-1:0] ready
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    logic en_d;
    logic val_d;
    logic val_q;

    // A clear from a newly issued writer wins over a same-cycle write-back.
    always_comb begin
      en_d  = set_vec[g] | clr_vec[g];
      val_d = ~clr_vec[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= 1'b1;
      else if (en_d) val_q <= val_d;
    end

    assign ready[g] = val_q;
  end

endmodule

// File: rtl/regval_scoreboard.sv
module regval_scoreboard
  import sb_pkg::*;
#(
  parameter  int NUM_REGS = 32,
  parameter  int NUM_SRC  = 2,
  localparam int ID_W     = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    iss_req,
  input  logic [NUM_SRC-1:0]      iss_src_use,
  input  logic [NUM_SRC*ID_W-1:0] iss_src_id,
  input  logic                    iss_dst_use,
  input  logic [ID_W-1:0]         iss_dst_id,
  input  logic                    wb_en,
  input  logic [ID_W-1:0]         wb_id,
  output logic                    iss_go,
  output logic                    iss_stall,
  output logic [NUM_REGS-1:0]     ready_o
);

  logic                rst_q_n;
  logic [NUM_REGS-1:0] wb_vec;
  logic [NUM_REGS-1:0] clr_vec;
  logic [NUM_REGS-1:0] ready_eff;
  sb_haz_t             haz;
  logic                go_d;

  sb_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_q_n)
  );

  sb_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_wb_dec (
    .en     (wb_en),
    .id     (wb_id),
    .onehot (wb_vec)
  );

  // A write-back landing this cycle already counts as ready for the check.
  assign ready_eff = ready_o | wb_vec;

  sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_haz (
    .ready_eff (ready_eff),
    .src_use   (iss_src_use),
    .src_id    (iss_src_id),
    .dst_use   (iss_dst_use),
    .dst_id    (iss_dst_id),
    .haz       (haz)
  );

  always_comb begin
    iss_stall = iss_req && sb_any_haz(haz);
    go_d      = iss_req && !sb_any_haz(haz);
  end

  assign iss_go = go_d;

  sb_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_clr_dec (
    .en     (go_d && iss_dst_use),
    .id     (iss_dst_id),
    .onehot (clr_vec)
  );

  sb_valid_bits #(.NUM_REGS(NUM_REGS)) u_bits (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .set_vec (wb_vec),
    .clr_vec (clr_vec),
    .ready   (ready_o)
  );

endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  parameter int ID_W     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_req,
  input logic                iss_dst_use,
  input logic [ID_W-1:0]     iss_dst_id,
  input logic                wb_en,
  input logic [ID_W-1:0]     wb_id,
  input logic                iss_go,
  input logic                iss_stall,
  input logic [NUM_REGS-1:0] ready_o
);

  AST_GO_CLEARS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_go && iss_dst_use) |=> !ready_o[$past(iss_dst_id)]); // R2

  AST_WB_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(iss_go && iss_dst_use && iss_dst_id == wb_id)) |=> ready_o[$past(wb_id)]); // R5

  AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_stall && !wb_en) |=> (ready_o == $past(ready_o))); // R3

  AST_PENDING_DST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_req && iss_dst_use && !ready_o[iss_dst_id] && !(wb_en && wb_id == iss_dst_id)) |-> !iss_go); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_req |-> (!iss_go && !iss_stall)); // R11

  AST_GO_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    iss_req |-> (iss_go != iss_stall)); // R2

  AST_RESET_READY: assert property (@(posedge clk)
    !rst_n |=> (ready_o == '1)); // R1

endmodule

bind regval_scoreboard sb_chk #(
  .NUM_REGS (NUM_REGS),
  .NUM_SRC  (NUM_SRC),
  .ID_W     (ID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .iss_req     (iss_req),
  .iss_dst_use (iss_dst_use),
  .iss_dst_id  (iss_dst_id),
  .wb_en       (wb_en),
  .wb_id       (wb_id),
  .iss_go      (iss_go),
  .iss_stall   (iss_stall),
  .ready_o     (ready_o)
);

// File: tb/tb_regval_scoreboard.sv
`timescale 1ns/1ps
module tb_regval_scoreboard;

  localparam int NR = 8;
  localparam int NS = 2;
  localparam int IW = $clog2(NR);

  logic          clk;
  logic          arst_n;
  logic          iss_req;
  logic [NS-1:0] iss_src_use;
  logic [NS*IW-1:0] iss_src_id;
  logic          iss_dst_use;
  logic [IW-1:0] iss_dst_id;
  logic          wb_en;
  logic [IW-1:0] wb_id;
  logic          iss_go;
  logic          iss_stall;
  logic [NR-1:0] ready_o;

  logic [NR-1:0] exp_rdy;
  logic          last_go;
  int            n_chk;
  int            n_fail;
  bit            done;

  regval_scoreboard #(.NUM_REGS(NR), .NUM_SRC(NS)) dut (
    .clk(clk), .arst_n(arst_n), .iss_req(iss_req), .iss_src_use(iss_src_use),
    .iss_src_id(iss_src_id), .iss_dst_use(iss_dst_use), .iss_dst_id(iss_dst_id),
    .wb_en(wb_en), .wb_id(wb_id), .iss_go(iss_go), .iss_stall(iss_stall),
    .ready_o(ready_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // One cycle: drive at the falling edge, check the same-cycle answer,
  // then check the ready vector after the rising edge.
  task automatic step(input logic req, input logic ua, input int a,
                      input logic ub, input int b, input logic ud, input int d,
                      input logic we, input int w, input string tag);
    logic [NR-1:0] eff;
    logic st;
    logic gx;
    iss_req     = req;
    iss_src_use = {ub, ua};
    iss_src_id  = {IW'(b), IW'(a)};
    iss_dst_use = ud;
    iss_dst_id  = IW'(d);
    wb_en       = we;
    wb_id       = IW'(w);
    #1;
    eff = exp_rdy;
    if (we) eff[w] = 1'b1;
    st = req && ((ua && !eff[a]) || (ub && !eff[b]) || (ud && !eff[d]));
    gx = req && !st;
    chk({tag, " stall"}, 32'(iss_stall), 32'(st));
    chk({tag, " go"},    32'(iss_go),    32'(gx));
    last_go = iss_go;
    @(posedge clk);
    #1;
    if (we) exp_rdy[w] = 1'b1;
    if (gx && ud) exp_rdy[d] = 1'b0;
    chk({tag, " ready"}, 32'(ready_o), 32'(exp_rdy));
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wb(input int w, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, w, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0; last_go = 0;
    arst_n = 1'b0;
    iss_req = 0; iss_src_use = '0; iss_src_id = '0; iss_dst_use = 0;
    iss_dst_id = '0; wb_en = 0; wb_id = '0;
    exp_rdy = '1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 32'(ready_o), 32'({NR{1'b1}}));
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", 32'(ready_o), 32'({NR{1'b1}}));

    // Sweep: every pending register against every source slot and destination.
    for (int p = 0; p < NR; p++) begin
      for (int a = 0; a < NR; a++) begin
        step(1, 0, 0, 0, 0, 1, p, 0, 0, "R2 issue writer");
        step(1, 1, a, 0, 0, 0, 0, 0, 0, "R3 src0 sweep");
        step(1, 0, 0, 1, a, 0, 0, 0, 0, "R3 src1 sweep");
        step(1, 0, 0, 0, 0, 1, a, 0, 0, "R4 dst sweep");
        wb(a, "R5 writeback");
        wb(p, "R5 writeback");
      end
    end

    // R9: unused fields name a pending register and are ignored.
    step(1, 0, 0, 0, 0, 1, 2, 0, 0, "R2 pend r2");
    step(1, 0, 2, 0, 2, 0, 2, 0, 0, "R9 unused ids");
    chk("R9 go with unused pending ids", 32'(last_go), 32'd1);
    chk("R9 r2 still pending", 32'(ready_o[2]), 32'd0);

    // R11: no request, no clear.
    step(0, 0, 0, 0, 0, 1, 4, 0, 0, "R11 idle");
    chk("R11 r4 untouched", 32'(ready_o[4]), 32'd1);

    // R6: same-cycle write-back bypass for a reader.
    step(1, 1, 2, 1, 2, 0, 0, 1, 2, "R6 bypass");
    chk("R6 reader proceeds", 32'(last_go), 32'd1);

    // R7: same-cycle write-back and new writer of the same register.
    step(1, 0, 0, 0, 0, 1, 6, 0, 0, "R2 pend r6");
    step(1, 0, 0, 0, 0, 1, 6, 1, 6, "R7 wb and issue");
    chk("R7 writer proceeds", 32'(last_go), 32'd1);
    chk("R7 bit stays clear", 32'(ready_o[6]), 32'd0);
    wb(6, "R5 release r6");

    // R8: self-dependent instruction.
    step(1, 1, 1, 0, 0, 1, 1, 0, 0, "R8 self ready");
    chk("R8 proceeds when ready", 32'(last_go), 32'd1);
    step(1, 1, 1, 0, 0, 1, 1, 0, 0, "R8 self pending");
    chk("R8 stalls when pending", 32'(last_go), 32'd0);
    wb(1, "R5 release r1");

    // R10: two readers waiting on one pending register.
    step(1, 0, 0, 0, 0, 1, 5, 0, 0, "R2 pend r5");
    step(1, 1, 5, 0, 0, 1, 0, 0, 0, "R10 reader A");
    chk("R10 reader A waits", 32'(last_go), 32'd0);
    step(1, 0, 0, 1, 5, 1, 7, 0, 0, "R10 reader B");
    chk("R10 reader B waits", 32'(last_go), 32'd0);
    wb(5, "R10 release");
    step(1, 1, 5, 0, 0, 1, 0, 0, 0, "R10 reader A go");
    chk("R10 reader A proceeds", 32'(last_go), 32'd1);
    step(1, 0, 0, 1, 5, 1, 7, 0, 0, "R10 reader B go");
    chk("R10 reader B proceeds", 32'(last_go), 32'd1);
    wb(0, "R5 release r0");
    wb(7, "R5 release r7");

    // R4: write r3, write r3, read r3 -- reader must see the second write.
    step(1, 1, 4, 1, 1, 1, 3, 0, 0, "R4 first writer");
    chk("R4 first writer goes", 32'(last_go), 32'd1);
    step(1, 1, 4, 1, 2, 1, 3, 0, 0, "R4 second writer");
    chk("R4 second writer held", 32'(last_go), 32'd0);
    step(1, 1, 4, 1, 2, 1, 3, 1, 3, "R4 second writer at first wb");
    chk("R4 second writer goes on first wb", 32'(last_go), 32'd1);
    step(1, 1, 3, 1, 2, 1, 5, 0, 0, "R4 reader");
    chk("R4 reader waits for second wb", 32'(last_go), 32'd0);
    step(1, 1, 3, 1, 2, 1, 5, 1, 3, "R4 reader at second wb");
    chk("R4 reader goes on second wb", 32'(last_go), 32'd1);
    wb(5, "R5 release r5");
    idle("R11 final idle");
    chk("R1 all ready at end", 32'(ready_o), 32'({NR{1'b1}}));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule